// File: doc/BRIEF.md
# Non-Preemptive Priority Process Scheduler

This block chooses which process owns the processor of a quantum-network node. It keeps a fixed table of process slots. Each slot holds a state (idle, ready, running or waiting) and a priority level. Slot 0 is reserved for the network process, which always sits at the top priority level. That process is released at every time-division slot boundary. Slots 1 and up belong to user processes. A user process is submitted with a priority, runs until it reports done, or gives up the processor to wait for entangled pairs. It returns to the ready set when the awaited deliveries have arrived.

A running process is never displaced. The scheduler only chooses again after the running process leaves. The choice is the highest ready priority level, and within that level the process that became ready first. While nothing runs, any ready process is dispatched on the next clock edge. A waiting process holds a mask of awaited pair slots, and pair deliveries accumulate in a shared delivered mask. The wake test compares the two according to the wait kind. The pairs a process consumes are removed from the delivered mask when it wakes.

Top module: `proc_sched`

## Requirements
- R1: After reset no process runs (`run_valid` low), every slot is idle and `overrun` is low.
- R2: A running process stays on the processor, with `run_pid` unchanged, until it asserts `done_valid` or `yield_valid`, even when a higher-priority process becomes ready.
- R3: The edge that samples `done_valid` or `yield_valid` from the running process drops `run_valid`. The next choice is made at the following edge. When nothing runs and at least one process is ready, the next edge dispatches one. When nothing is ready, `run_valid` stays low. `done_valid` takes precedence over `yield_valid`, and both are ignored while nothing runs.
- R4: The dispatched process is taken from the highest ready priority level, where a larger number means more urgent. Slot 0 always has level NPRIO-1. A user submit level of NPRIO-1 or more is stored as NPRIO-2.
- R5: Within one level, the process that entered the ready state earliest is chosen first. Processes that enter in the same cycle are ordered by lower slot number first.
- R6: A `slot_start` pulse while slot 0 is idle makes slot 0 ready.
- R7: A `slot_start` pulse while slot 0 is ready or running queues no second instance and sets `overrun`, which stays high until reset.
- R8: `yield_valid` moves the running process to waiting and records `yield_mode`: 0 wait-all, 1 wait-any, 2 single pair, 3 treated as wait-all.
- R9: A wait-all process becomes ready once every bit of its `yield_mask` is present in the delivered mask. An empty mask wakes it at once.
- R10: A wait-any process becomes ready once any bit of its `yield_mask` is delivered. An empty mask wakes it at once.
- R11: A single-pair waiter awaits only pair `yield_pair`, and `yield_mask` is ignored for it.
- R12: A submit naming slot 0, or a slot that is not idle, has no effect.
- R13: A `deliver_valid` pulse sets bit `deliver_pair` of the delivered mask. The bits awaited by a process that wakes are cleared from that mask in the same edge, so a later waiter on the same pair needs a new delivery. A waiting process is tested against the delivered mask as registered, so a wake occurs at the edge after the delivery that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start | input | 1 | Time-division slot boundary strobe |
| submit_valid | input | 1 | Submit a user process |
| submit_pid | input | PW | Slot number of submitted process |
| submit_lvl | input | LW | Requested priority level |
| yield_valid | input | 1 | Running process waits for entanglement |
| yield_mode | input | 2 | Wait kind: 0 all, 1 any, 2 single, 3 all |
| yield_mask | input | NPAIR | Awaited pair slots for all/any |
| yield_pair | input | AW | Awaited pair for single mode |
| done_valid | input | 1 | Running process has finished |
| deliver_valid | input | 1 | Entanglement unit delivered a pair |
| deliver_pair | input | AW | Pair slot delivered |
| run_valid | output | 1 | A process owns the processor |
| run_pid | output | PW | Slot number of the running process |
| overrun | output | 1 | Sticky slot-boundary overrun flag |

## Verification
Several functions can act in the same cycle, and two pairs are the risky ones. The first is a pair delivery arriving in the same edge in which a waking process consumes its awaited bits. The second is a slot boundary landing in the same cycle as the network process reporting done, or while it still sits in the ready queue. A reference model, written from the requirements with its own arrival stamps, runs alongside the design. Directed sequences place these coincidences on purpose, and a long pseudo-random sweep with frequent strobes and deliveries makes them collide at random. Every cycle, the model and the design are compared on `run_valid`, `run_pid` and `overrun`, which shows whether a wake, a release or a duplicate was gained or lost.

// File: rtl/proc_sched_pkg.sv
package proc_sched_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_READY = 2'd1,
    PS_RUN   = 2'd2,
    PS_WAIT  = 2'd3
  } pstate_e;

  localparam logic [1:0] WM_ALL = 2'd0;
  localparam logic [1:0] WM_ANY = 2'd1;
  localparam logic [1:0] WM_ONE = 2'd2;

endpackage

// File: rtl/proc_slot.sv
module proc_slot
  import proc_sched_pkg::*;
#(
  parameter int NPAIR = 8,
  parameter int LW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_load,
  input  logic [LW-1:0]    load_lvl,
  input  logic             req_run,
  input  logic             req_finish,
  input  logic             req_park,
  input  logic [1:0]       park_mode,
  input  logic [NPAIR-1:0] park_mask,
  input  logic [NPAIR-1:0] delivered,
  output pstate_e          state,
  output logic [LW-1:0]    lvl,
  output logic [NPAIR-1:0] wait_mask,
  output logic             wake,
  output logic             enter
);

  logic [1:0] mode_q;

  // single-pair waits arrive as a one-hot mask, so they share the all-test
  function automatic logic wake_ok(input logic [1:0] m, input logic [NPAIR-1:0] want,
                                   input logic [NPAIR-1:0] got);
    if (m == WM_ANY) return (want == '0) || ((want & got) != '0);
    return (want & ~got) == '0;
  endfunction

  assign wake  = (state == PS_WAIT) && wake_ok(mode_q, wait_mask, delivered);
  assign enter = ((state == PS_IDLE) && req_load) || wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      lvl       <= '0;
      mode_q    <= WM_ALL;
      wait_mask <= '0;
    end else begin
      unique case (state)
        PS_IDLE:  if (req_load) begin
                    state <= PS_READY;
                    lvl   <= load_lvl;
                  end
        PS_READY: if (req_run) state <= PS_RUN;
        PS_RUN:   if (req_finish) state <= PS_IDLE;
                  else if (req_park) begin
                    state     <= PS_WAIT;
                    mode_q    <= park_mode;
                    wait_mask <= park_mask;
                  end
        PS_WAIT:  if (wake) state <= PS_READY;
        default:  state <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/proc_age.sv
module proc_age #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   enter,
  output logic [N*N-1:0] older   // bit i*N+j: slot i entered ready before slot j
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (enter[i] && enter[j])  older[i*N+j] <= (i < j);
          else if (enter[i])         older[i*N+j] <= 1'b0;
          else if (enter[j])         older[i*N+j] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/proc_pick.sv
module proc_pick #(
  parameter int N  = 4,
  parameter int LW = 2,
  parameter int PW = 2
) (
  input  logic [N-1:0]    ready,
  input  logic [N*LW-1:0] lvl_flat,
  input  logic [N*N-1:0]  older,
  output logic            any,
  output logic [PW-1:0]   pid
);

  logic [LW-1:0] best;
  logic [N-1:0]  cand;

  always_comb begin
    best = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && (!any || lvl_flat[i*LW +: LW] > best)) begin
        best = lvl_flat[i*LW +: LW];
        any  = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) cand[i] = ready[i] && (lvl_flat[i*LW +: LW] == best);
  end

  always_comb begin
    logic hit;
    logic beaten;
    hit = 1'b0;
    pid = '0;
    for (int i = 0; i < N; i++) begin
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && cand[j] && older[j*N+i]) beaten = 1'b1;
      if (cand[i] && !beaten && !hit) begin
        pid = PW'(i);
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/proc_sched.sv
module proc_sched
  import proc_sched_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NPRIO = 4,
  parameter int NPAIR = 8,
  localparam int PW = $clog2(NPROC),
  localparam int LW = $clog2(NPRIO),
  localparam int AW = $clog2(NPAIR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             submit_valid,
  input  logic [PW-1:0]    submit_pid,
  input  logic [LW-1:0]    submit_lvl,
  input  logic             yield_valid,
  input  logic [1:0]       yield_mode,
  input  logic [NPAIR-1:0] yield_mask,
  input  logic [AW-1:0]    yield_pair,
  input  logic             done_valid,
  input  logic             deliver_valid,
  input  logic [AW-1:0]    deliver_pair,
  output logic             run_valid,
  output logic [PW-1:0]    run_pid,
  output logic             overrun
);

  localparam logic [LW-1:0] NET_LVL  = LW'(NPRIO - 1);
  localparam logic [LW-1:0] USER_TOP = LW'(NPRIO - 2);

  function automatic logic [LW-1:0] user_lvl(input logic [LW-1:0] x);
    return (x >= NET_LVL) ? USER_TOP : x;
  endfunction

  function automatic logic [NPAIR-1:0] pair_bit(input logic [AW-1:0] p);
    return {{(NPAIR-1){1'b0}}, 1'b1} << p;
  endfunction

  // named internal events
  logic             cur_valid_q;
  logic [PW-1:0]    cur_pid_q;
  logic             finish, park, go_dispatch, any_ready;
  logic [PW-1:0]    pick_pid;
  logic [NPROC-1:0] ready_vec, run_vec, enter_vec, wake_vec;
  logic [NPROC*LW-1:0]  lvl_flat;
  logic [NPROC*NPROC-1:0] older;
  logic [NPAIR-1:0] deliv_q, consume, park_mask;
  logic             overrun_q, net_busy;
  pstate_e          st [NPROC];
  logic [NPAIR-1:0] wmask [NPROC];

  assign finish      = cur_valid_q && done_valid;
  assign park        = cur_valid_q && yield_valid && !done_valid;
  assign go_dispatch = !cur_valid_q && any_ready;
  assign park_mask   = (yield_mode == WM_ONE) ? pair_bit(yield_pair) : yield_mask;
  assign net_busy    = (st[0] == PS_READY) || (st[0] == PS_RUN);

  for (genvar i = 0; i < NPROC; i++) begin : g_slot
    logic          load_i;
    logic [LW-1:0] load_lvl_i;
    logic [LW-1:0] lvl_i;
    if (i == 0) begin : g_net
      assign load_i     = slot_start;
      assign load_lvl_i = NET_LVL;
    end else begin : g_user
      assign load_i     = submit_valid && (submit_pid == PW'(i));
      assign load_lvl_i = user_lvl(submit_lvl);
    end
    proc_slot #(.NPAIR(NPAIR), .LW(LW)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_load  (load_i),
      .load_lvl  (load_lvl_i),
      .req_run   (go_dispatch && (pick_pid == PW'(i))),
      .req_finish(finish && (cur_pid_q == PW'(i))),
      .req_park  (park && (cur_pid_q == PW'(i))),
      .park_mode (yield_mode),
      .park_mask (park_mask),
      .delivered (deliv_q),
      .state     (st[i]),
      .lvl       (lvl_i),
      .wait_mask (wmask[i]),
      .wake      (wake_vec[i]),
      .enter     (enter_vec[i])
    );
    assign lvl_flat[i*LW +: LW] = lvl_i;
    assign ready_vec[i] = (st[i] == PS_READY);
    assign run_vec[i]   = (st[i] == PS_RUN);
  end

  proc_age #(.N(NPROC)) age_i (
    .clk  (clk),
    .rst_n(rst_n),
    .enter(enter_vec),
    .older(older)
  );

  proc_pick #(.N(NPROC), .LW(LW), .PW(PW)) pick_i (
    .ready   (ready_vec),
    .lvl_flat(lvl_flat),
    .older   (older),
    .any     (any_ready),
    .pid     (pick_pid)
  );

  always_comb begin
    consume = '0;
    for (int i = 0; i < NPROC; i++)
      if (wake_vec[i]) consume = consume | wmask[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid_q <= 1'b0;
      cur_pid_q   <= '0;
      deliv_q     <= '0;
      overrun_q   <= 1'b0;
    end else begin
      if (finish || park) begin
        cur_valid_q <= 1'b0;
      end else if (go_dispatch) begin
        cur_valid_q <= 1'b1;
        cur_pid_q   <= pick_pid;
      end
      deliv_q <= (deliv_q | (deliver_valid ? pair_bit(deliver_pair) : '0)) & ~consume;
      if (slot_start && net_busy) overrun_q <= 1'b1;
    end
  end

  assign run_valid = cur_valid_q;
  assign run_pid   = cur_pid_q;
  assign overrun   = overrun_q;

endmodule

// File: rtl/proc_sched_chk.sv
module proc_sched_chk #(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_valid,
  input logic             yield_valid,
  input logic             run_valid,
  input logic [PW-1:0]    run_pid,
  input logic             overrun,
  input logic             go_dispatch,
  input logic [PW-1:0]    pick_pid,
  input logic [NPROC-1:0] ready_vec,
  input logic [NPROC-1:0] run_vec
);

  a_r2_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid && !done_valid && !yield_valid |=> run_valid && run_pid == $past(run_pid));

  a_r3_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid && (done_valid || yield_valid) |=> !run_valid);

  a_r3_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    go_dispatch |=> run_valid && run_pid == $past(pick_pid));

  a_r4_net_first: assert property (@(posedge clk) disable iff (!rst_n)
    go_dispatch && ready_vec[0] |-> pick_pid == '0);

  a_r2_one_runner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_vec) <= 1 && (run_valid == (run_vec != '0)));

  a_r3_runner_matches: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> run_vec[run_pid]);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind proc_sched proc_sched_chk #(.NPROC(NPROC), .PW(PW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_valid (done_valid),
  .yield_valid(yield_valid),
  .run_valid  (run_valid),
  .run_pid    (run_pid),
  .overrun    (overrun),
  .go_dispatch(go_dispatch),
  .pick_pid   (pick_pid),
  .ready_vec  (ready_vec),
  .run_vec    (run_vec)
);

// File: tb/proc_sched_tb_top.sv
module proc_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_start = 0, submit_valid = 0, yield_valid = 0, done_valid = 0, deliver_valid = 0;
  logic [1:0] submit_pid = 0, submit_lvl = 0, yield_mode = 0;
  logic [7:0] yield_mask = 0;
  logic [2:0] yield_pair = 0, deliver_pair = 0;
  logic       run_valid, overrun;
  logic [1:0] run_pid;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;   // 50 MHz

  proc_sched dut_i (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .submit_valid(submit_valid), .submit_pid(submit_pid), .submit_lvl(submit_lvl),
    .yield_valid(yield_valid), .yield_mode(yield_mode), .yield_mask(yield_mask),
    .yield_pair(yield_pair), .done_valid(done_valid),
    .deliver_valid(deliver_valid), .deliver_pair(deliver_pair),
    .run_valid(run_valid), .run_pid(run_pid), .overrun(overrun)
  );

  // reference model: states 0 idle, 1 ready, 2 running, 3 waiting
  int       m_st [4], m_lv [4], m_stamp [4], m_mode [4];
  bit [7:0] m_mask [4];
  bit [7:0] m_deliv;
  bit       m_curv, m_ovr;
  int       m_cur, m_seq;

  function automatic bit woken(int mode, bit [7:0] want, bit [7:0] have);
    if (mode == 1) return want == 0 || (want & have) != 0;
    return (want & have) == want;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_st[i] = 0; m_lv[i] = 0; m_stamp[i] = 0; m_mode[i] = 0; m_mask[i] = 0;
      end
      m_lv[0] = 3; m_deliv = 0; m_curv = 0; m_ovr = 0; m_cur = 0; m_seq = 0;
    end else begin
      automatic int  ns [4];
      automatic bit  ent [4];
      automatic bit [7:0] used = 0;
      automatic int  best = -1, bstamp = 0, pk = 0;
      automatic bit  fin = m_curv && done_valid;
      automatic bit  prk = m_curv && yield_valid && !done_valid;
      for (int i = 0; i < 4; i++) begin ns[i] = m_st[i]; ent[i] = 0; end
      for (int i = 0; i < 4; i++)
        if (m_st[i] == 1 && (m_lv[i] > best || (m_lv[i] == best && m_stamp[i] < bstamp))) begin
          best = m_lv[i]; bstamp = m_stamp[i]; pk = i;
        end
      for (int i = 0; i < 4; i++)
        if (m_st[i] == 3 && woken(m_mode[i], m_mask[i], m_deliv)) begin
          ns[i] = 1; ent[i] = 1; used |= m_mask[i];
        end
      if (submit_valid && submit_pid != 0 && m_st[submit_pid] == 0) begin
        ns[submit_pid] = 1; ent[submit_pid] = 1;
        m_lv[submit_pid] = (submit_lvl > 2) ? 2 : int'(submit_lvl);
      end
      if (slot_start) begin
        if (m_st[0] == 0) begin ns[0] = 1; ent[0] = 1; end
        else if (m_st[0] != 3) m_ovr = 1;
      end
      for (int i = 0; i < 4; i++) if (ent[i]) begin m_stamp[i] = m_seq; m_seq++; end
      if (!m_curv && best >= 0) begin ns[pk] = 2; m_curv = 1; m_cur = pk; end
      else if (fin) begin ns[m_cur] = 0; m_curv = 0; end
      else if (prk) begin
        ns[m_cur] = 3; m_curv = 0;
        m_mode[m_cur] = int'(yield_mode);
        m_mask[m_cur] = (yield_mode == 2) ? (8'd1 << yield_pair) : yield_mask;
      end
      m_deliv = (m_deliv | (deliver_valid ? (8'd1 << deliver_pair) : 8'd0)) & ~used;
      for (int i = 0; i < 4; i++) m_st[i] = ns[i];
    end
  end

  task automatic compare();
    n_cmp++;
    if (run_valid !== m_curv) begin
      n_bad++; $display("FAIL %s run_valid act=%0d exp=%0d", cur_req, run_valid, m_curv);
    end
    if (m_curv) begin
      n_cmp++;
      if (run_pid !== 2'(m_cur)) begin
        n_bad++; $display("FAIL %s run_pid act=%0d exp=%0d", cur_req, run_pid, m_cur);
      end
    end
    n_cmp++;
    if (overrun !== m_ovr) begin
      n_bad++; $display("FAIL %s overrun act=%0d exp=%0d", cur_req, overrun, m_ovr);
    end
  endtask

  // one clock: inputs already set at a falling edge; compare at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    slot_start = 0; submit_valid = 0; yield_valid = 0; done_valid = 0; deliver_valid = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic submit(int pid, int lvl);
    submit_valid = 1; submit_pid = 2'(pid); submit_lvl = 2'(lvl); step();
  endtask

  task automatic finish_one();
    done_valid = 1; step(); step();
  endtask

  task automatic wait_on(int mode, int mask, int pair);
    yield_valid = 1; yield_mode = 2'(mode); yield_mask = 8'(mask); yield_pair = 3'(pair); step();
  endtask

  task automatic deliver(int pair);
    deliver_valid = 1; deliver_pair = 3'(pair); step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare(); idle(2);

    cur_req = "R6"; slot_start = 1; step(); idle(2);
    cur_req = "R7"; slot_start = 1; step(); idle(1);
    cur_req = "R3"; done_valid = 1; yield_valid = 1; step(); idle(2);
    cur_req = "R7"; slot_start = 1; step(); slot_start = 1; step(); idle(1);
    finish_one();

    cur_req = "R12"; submit(0, 1); idle(2);
    submit(1, 1); idle(1); submit(1, 0); submit(2, 1);
    cur_req = "R2"; slot_start = 1; step(); idle(3);
    cur_req = "R3"; finish_one(); idle(1);
    cur_req = "R2"; finish_one(); finish_one(); idle(2);

    cur_req = "R4"; submit(1, 0); submit(2, 3); submit(3, 1); slot_start = 1; step();
    finish_one(); finish_one(); finish_one(); finish_one(); idle(2);

    cur_req = "R5"; submit(1, 1); submit(3, 2); submit(2, 2); idle(1);
    finish_one(); finish_one(); finish_one(); idle(2);

    cur_req = "R8"; submit(1, 1); idle(1); wait_on(0, 'h06, 0); idle(2);
    cur_req = "R9"; deliver(1); idle(2); deliver(2); idle(3); finish_one();
    submit(2, 0); idle(1); wait_on(3, 0, 0); idle(3); finish_one();

    cur_req = "R10"; submit(2, 1); idle(1); wait_on(1, 'h30, 0); idle(2);
    cur_req = "R13"; submit(1, 1); idle(1); wait_on(0, 'h20, 0);
    deliver(5); idle(3); finish_one(); idle(2);
    deliver(5); idle(3); finish_one(); idle(1);
    cur_req = "R5"; submit(1, 1); idle(1); wait_on(1, 'h01, 0);
    submit(2, 1); idle(1); wait_on(1, 'h01, 0);
    deliver(0); idle(2); finish_one(); finish_one(); idle(1);

    cur_req = "R11"; submit(3, 0); idle(1); wait_on(2, 'hFF, 7);
    deliver(6); idle(3); deliver(7); idle(3); finish_one(); idle(1);

    cur_req = "R3";
    begin
      bit [31:0] r = 32'h1234_5678;
      for (int c = 0; c < 6000; c++) begin
        r = r * 32'd1664525 + 32'd1013904223;
        slot_start    = (r[31:27] == 0);
        submit_valid  = r[26];
        submit_pid    = r[25:24];
        submit_lvl    = r[23:22];
        done_valid    = (r[21:19] == 0);
        yield_valid   = (r[18:16] == 0);
        yield_mode    = r[15:14];
        yield_mask    = {4'b0, r[13:10]};
        yield_pair    = {1'b0, r[9:8]};
        deliver_valid = r[7] & r[6];
        deliver_pair  = {1'b0, r[5:4]};
        step();
      end
    end
    idle(4);
    summary();
  end

endmodule